// File: doc/BRIEF.md
# Two-Level Translation Table Walker

The walker turns a 32-bit virtual address into a physical address by reading translation descriptors from memory. It accepts one lookup at a time through a valid/ready request port. A translation table base value comes in on its own input and is captured together with the virtual address. The walker always reads a first-level descriptor. If that descriptor points at a coarse second-level table, it reads a second descriptor as well. Both reads go out on a plain 32-bit memory read port, which has a request handshake and a response strobe. The walker sends these reads to physical addresses as they are and never translates its own table fetches.

The result leaves through a valid/ready response port. A good walk returns the physical address together with the cacheable, bufferable, domain and access-permission attributes. A failed walk returns a translation fault with a status code and the domain. In both cases a flag says whether the walk ended at a 1 MB section or at a 4 KB small page. The block performs no permission check and keeps no cache of earlier walks.

Top module: `tt_walker`

## Requirements
- R1: The first-level read address is {ttb[31:14], va[31:20], 2'b00}. Bits [13:0] of the table base have no effect. For example, base 0x4000 and VA 0x12345678 read 0x448C.
- R2: A first-level descriptor d1 with d1[1:0]=2'b10 is a section. The result is pa={d1[31:20], va[19:0]}, cache=d1[3], buffer=d1[2], domain=d1[8:5], ap=d1[11:10], page=0, fault=0. The walk makes exactly one memory read.
- R3: When d1[1:0]=2'b01, a second read follows at {d1[31:10], va[19:12], 2'b00}. For example, d1=0xABCDE001 with VA 0x12345678 reads 0xABCDE114.
- R4: A second-level descriptor d2 with d2[1:0]=2'b10 is a small page. The result is pa={d2[31:12], va[11:0]}, cache=d2[3], buffer=d2[2], domain=d1[8:5], page=1, fault=0. The walk makes exactly two memory reads.
- R5: For a small page, ap is d2[5+2k:4+2k], where k=va[11:10]. So subpage 0 takes bits [5:4] and subpage 3 takes bits [11:10].
- R6: When d1[1:0] is 2'b00 or 2'b11, the walk ends after one read with fault=1, status=4'h5, domain=d1[8:5] and page=0. In this case pa, cache, buffer and ap are all 0.
- R7: When a second-level descriptor has d2[1:0] other than 2'b10, the result is fault=1, status=4'h7, domain=d1[8:5] and page=1. In this case pa, cache, buffer and ap are all 0.
- R8: req_ready_o is high only while no walk is in progress. A request presented during a walk is not taken and does not change the result. The table base and VA are captured in the accepting cycle.
- R9: While mem_req_ready_i is low, mem_req_valid_o stays high and mem_req_addr_o stays constant.
- R10: While rsp_ready_i is low, rsp_valid_o stays high and all response fields stay constant. Once the response handshake completes, req_ready_o is high in the next cycle.
- R11: During reset, req_ready_o=1, mem_req_valid_o=0 and rsp_valid_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ttb_i | input | 32 | Translation table base |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Lookup request ready |
| req_va_i | input | 32 | Virtual address to translate |
| mem_req_valid_o | output | 1 | Descriptor read request valid |
| mem_req_ready_i | input | 1 | Descriptor read request accepted |
| mem_req_addr_o | output | 32 | Physical address of the descriptor |
| mem_rsp_valid_i | input | 1 | Descriptor read data valid |
| mem_rsp_data_i | input | 32 | Descriptor read data |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Result accepted |
| rsp_pa_o | output | 32 | Physical address |
| rsp_cache_o | output | 1 | Cacheable attribute |
| rsp_buffer_o | output | 1 | Bufferable attribute |
| rsp_domain_o | output | 4 | Domain number |
| rsp_ap_o | output | 2 | Access permission field |
| rsp_page_o | output | 1 | 1 if the walk ended at the second level |
| rsp_fault_o | output | 1 | Translation fault |
| rsp_status_o | output | 4 | Fault status (5 or 7), 0 on success |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:
- A table base with its low bits set. A walker that adds or ORs in those bits reads the wrong first-level address.
- Every subpage index of a small page. A wrong AP field select returns the permission of a neighbouring subpage.
- Both unused first-level encodings and all three invalid second-level encodings. A decoder that treats any of these as valid, or that reports status 5 where 7 is due, gives a wrong result or an extra read.
- A new request held on the request port with a different VA for the whole walk. A walker that samples that request late, or accepts it, returns a wrong address.
- Stalls on both handshakes. These catch a request address or a result that moves before it is taken.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned AW        = 32;
  localparam int unsigned TTB_LSB   = 14;
  localparam int unsigned SEC_SHIFT = 20;
  localparam int unsigned PG_SHIFT  = 12;
  localparam int unsigned L2B_LSB   = 10;
  localparam int unsigned DOM_W     = 4;
  localparam int unsigned AP_W      = 2;
  localparam int unsigned N_SUBPG   = 4;
  localparam int unsigned ST_W      = 4;

  localparam logic [1:0] L1_COARSE = 2'b01;
  localparam logic [1:0] L1_SECT   = 2'b10;
  localparam logic [1:0] L2_SMALL  = 2'b10;
  localparam logic [ST_W-1:0] FS_SECT = 4'h5;
  localparam logic [ST_W-1:0] FS_PAGE = 4'h7;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_RESP
  } walk_st_e;

  typedef struct packed {
    logic [AW-1:0]    pa;
    logic             cache;
    logic             buffer;
    logic [DOM_W-1:0] domain;
    logic [AP_W-1:0]  ap;
    logic             page;
    logic             fault;
    logic [ST_W-1:0]  status;
  } walk_res_t;
endpackage

// File: rtl/tt_addr_gen.sv
module tt_addr_gen
  import tt_pkg::*;
(
  input  logic [AW-1:TTB_LSB]  ttb_hi_i,
  input  logic [AW-1:PG_SHIFT] va_hi_i,
  input  logic [AW-1:L2B_LSB]  l2_base_i,
  output logic [AW-1:0]        l1_addr_o,
  output logic [AW-1:0]        l2_addr_o
);
  assign l1_addr_o = {ttb_hi_i, va_hi_i[AW-1:SEC_SHIFT], 2'b00};
  assign l2_addr_o = {l2_base_i, va_hi_i[SEC_SHIFT-1:PG_SHIFT], 2'b00};
endmodule

// File: rtl/tt_desc_decode.sv
module tt_desc_decode
  import tt_pkg::*;
(
  input  logic                 lvl2_i,
  input  logic [AW-1:0]        desc_i,
  input  logic [DOM_W-1:0]     l1_dom_i,
  input  logic [SEC_SHIFT-1:0] va_lo_i,
  output logic                 coarse_o,
  output walk_res_t            res_o
);
  localparam int unsigned SEL_W = $clog2(N_SUBPG);

  logic [AP_W-1:0] ap_f [N_SUBPG];
  for (genvar g = 0; g < N_SUBPG; g++) begin : g_ap
    assign ap_f[g] = desc_i[4 + AP_W*g +: AP_W];
  end

  logic unused_dec;
  assign unused_dec = desc_i[9];

  always_comb begin
    res_o    = '0;
    coarse_o = 1'b0;
    if (!lvl2_i) begin
      res_o.domain = desc_i[8:5];
      if (desc_i[1:0] == L1_SECT) begin
        res_o.pa     = {desc_i[AW-1:SEC_SHIFT], va_lo_i};
        res_o.cache  = desc_i[3];
        res_o.buffer = desc_i[2];
        res_o.ap     = desc_i[11:10];
      end else if (desc_i[1:0] == L1_COARSE) begin
        coarse_o = 1'b1;
      end else begin
        res_o.fault  = 1'b1;
        res_o.status = FS_SECT;
      end
    end else begin
      res_o.domain = l1_dom_i;
      res_o.page   = 1'b1;
      if (desc_i[1:0] == L2_SMALL) begin
        res_o.pa     = {desc_i[AW-1:PG_SHIFT], va_lo_i[PG_SHIFT-1:0]};
        res_o.cache  = desc_i[3];
        res_o.buffer = desc_i[2];
        res_o.ap     = ap_f[va_lo_i[PG_SHIFT-1 -: SEL_W]];
      end else begin
        res_o.fault  = 1'b1;
        res_o.status = FS_PAGE;
      end
    end
  end
endmodule

// File: rtl/tt_walker.sv
module tt_walker
  import tt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    ttb_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [AW-1:0]    req_va_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [AW-1:0]    mem_req_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [AW-1:0]    mem_rsp_data_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [AW-1:0]    rsp_pa_o,
  output logic             rsp_cache_o,
  output logic             rsp_buffer_o,
  output logic [DOM_W-1:0] rsp_domain_o,
  output logic [AP_W-1:0]  rsp_ap_o,
  output logic             rsp_page_o,
  output logic             rsp_fault_o,
  output logic [ST_W-1:0]  rsp_status_o
);
  walk_st_e              st_q;
  logic [AW-1:0]         va_q;
  logic [AW-1:TTB_LSB]   ttb_q;
  logic [AW-1:0]         d1_q;
  walk_res_t             res_q, dec_res;
  logic                  dec_coarse;
  logic [AW-1:0]         l1_addr, l2_addr;

  logic unused_top;
  assign unused_top = ^{ttb_i[TTB_LSB-1:0], d1_q[9], d1_q[4:0]};

  tt_addr_gen u_addr (
    .ttb_hi_i (ttb_q),
    .va_hi_i  (va_q[AW-1:PG_SHIFT]),
    .l2_base_i(d1_q[AW-1:L2B_LSB]),
    .l1_addr_o(l1_addr),
    .l2_addr_o(l2_addr)
  );

  tt_desc_decode u_dec (
    .lvl2_i  (st_q == S_L2_WAIT),
    .desc_i  (mem_rsp_data_i),
    .l1_dom_i(d1_q[8:5]),
    .va_lo_i (va_q[SEC_SHIFT-1:0]),
    .coarse_o(dec_coarse),
    .res_o   (dec_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      va_q  <= '0;
      ttb_q <= '0;
      d1_q  <= '0;
      res_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          va_q  <= req_va_i;
          ttb_q <= ttb_i[AW-1:TTB_LSB];
          st_q  <= S_L1_REQ;
        end
        S_L1_REQ: if (mem_req_ready_i) st_q <= S_L1_WAIT;
        S_L1_WAIT: if (mem_rsp_valid_i) begin
          d1_q <= mem_rsp_data_i;
          if (dec_coarse) st_q <= S_L2_REQ;
          else begin
            res_q <= dec_res;
            st_q  <= S_RESP;
          end
        end
        S_L2_REQ: if (mem_req_ready_i) st_q <= S_L2_WAIT;
        S_L2_WAIT: if (mem_rsp_valid_i) begin
          res_q <= dec_res;
          st_q  <= S_RESP;
        end
        S_RESP: if (rsp_ready_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (st_q == S_IDLE);
  assign mem_req_valid_o = (st_q == S_L1_REQ) || (st_q == S_L2_REQ);
  assign mem_req_addr_o  = (st_q == S_L2_REQ) ? l2_addr : l1_addr;
  assign rsp_valid_o     = (st_q == S_RESP);
  assign rsp_pa_o        = res_q.pa;
  assign rsp_cache_o     = res_q.cache;
  assign rsp_buffer_o    = res_q.buffer;
  assign rsp_domain_o    = res_q.domain;
  assign rsp_ap_o        = res_q.ap;
  assign rsp_page_o      = res_q.page;
  assign rsp_fault_o     = res_q.fault;
  assign rsp_status_o    = res_q.status;

  // R8: one walk in flight
  a_r8_single_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && (rsp_valid_o || mem_req_valid_o)));
  // R9: read request holds under stall
  a_r9_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));
  // R10: response holds under stall
  a_r10_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_pa_o)
      && $stable(rsp_ap_o) && $stable(rsp_status_o) && $stable(rsp_domain_o));
  // R10: ready returns after the response handshake
  a_r10_ready_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ready_i |=> req_ready_o);
  // R6, R7: fault status matches the level
  a_r6_r7_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> rsp_status_o == (rsp_page_o ? FS_PAGE : FS_SECT));
  // R2: section keeps the low 20 VA bits
  a_r2_sect_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o && !rsp_page_o |-> rsp_pa_o[SEC_SHIFT-1:0] == va_q[SEC_SHIFT-1:0]);
  // R4: small page keeps the low 12 VA bits
  a_r4_page_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o && rsp_page_o |-> rsp_pa_o[PG_SHIFT-1:0] == va_q[PG_SHIFT-1:0]);
endmodule

// File: tb/tt_walker_test.sv
`timescale 1ns/1ps
module tt_walker_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] ttb = 0, req_va = 0;
  logic        req_valid = 0, mem_req_ready = 0, mem_rsp_valid = 0, rsp_ready = 0;
  logic [31:0] mem_rsp_data = 0;
  logic        req_ready, mem_req_valid, rsp_valid;
  logic [31:0] mem_req_addr, rsp_pa;
  logic        rsp_cache, rsp_buffer, rsp_page, rsp_fault;
  logic [3:0]  rsp_domain, rsp_status;
  logic [1:0]  rsp_ap;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tt_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .ttb_i(ttb), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_va_i(req_va), .mem_req_valid_o(mem_req_valid),
    .mem_req_ready_i(mem_req_ready), .mem_req_addr_o(mem_req_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_pa_o(rsp_pa),
    .rsp_cache_o(rsp_cache), .rsp_buffer_o(rsp_buffer), .rsp_domain_o(rsp_domain),
    .rsp_ap_o(rsp_ap), .rsp_page_o(rsp_page), .rsp_fault_o(rsp_fault),
    .rsp_status_o(rsp_status)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic serve_read(input logic [31:0] exp_addr, input logic [31:0] data,
                            input int stall, input int lat, input string req);
    int n = 0;
    while (!mem_req_valid && n < 50) begin @(negedge clk); n++; end
    chk(mem_req_valid, {req, " read issued"}, {31'd0, mem_req_valid}, 32'd1);
    chk(mem_req_addr == exp_addr, {req, " read address"}, mem_req_addr, exp_addr);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(mem_req_valid && mem_req_addr == exp_addr, "R9 held request", mem_req_addr, exp_addr);
    end
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0;
    for (int i = 0; i < lat; i++) @(negedge clk);
    mem_rsp_valid = 1;
    mem_rsp_data  = data;
    @(negedge clk);
    mem_rsp_valid = 0;
    mem_rsp_data  = $urandom;
  endtask

  task automatic walk(input logic [31:0] tb, input logic [31:0] va,
                      input logic [31:0] d1, input logic [31:0] d2, input int rstall);
    logic [31:0] e_pa; logic e_c, e_b, e_pg, e_f; logic [3:0] e_dom, e_st; logic [1:0] e_ap;
    logic [31:0] a1, a2;
    bit coarse;
    int n = 0;
    a1 = {tb[31:14], va[31:20], 2'b00};
    a2 = {d1[31:10], va[19:12], 2'b00};
    coarse = (d1[1:0] == 2'b01);
    e_pa = 0; e_c = 0; e_b = 0; e_ap = 0; e_f = 0; e_st = 0; e_dom = d1[8:5]; e_pg = coarse;
    if (d1[1:0] == 2'b10) begin
      e_pa = {d1[31:20], va[19:0]}; e_c = d1[3]; e_b = d1[2]; e_ap = d1[11:10];
    end else if (!coarse) begin
      e_f = 1; e_st = 4'h5;
    end else if (d2[1:0] == 2'b10) begin
      e_pa = {d2[31:12], va[11:0]}; e_c = d2[3]; e_b = d2[2];
      e_ap = d2[4 + 2*va[11:10] +: 2];
    end else begin
      e_f = 1; e_st = 4'h7;
    end

    @(negedge clk);
    chk(req_ready, "R8 idle ready", {31'd0, req_ready}, 32'd1);
    req_valid = 1; req_va = va; ttb = tb;
    @(negedge clk);
    // R8: a competing request held for the whole walk must be ignored
    req_va = ~va; ttb = ~tb;
    chk(!req_ready, "R8 busy not ready", {31'd0, req_ready}, 32'd0);
    serve_read(a1, d1, $urandom_range(0, 2), $urandom_range(0, 3), "R1");
    if (coarse) serve_read(a2, d2, $urandom_range(0, 2), $urandom_range(0, 3), "R3");
    while (!rsp_valid && n < 50) begin
      if (mem_req_valid) begin
        chk(0, coarse ? "R4 read count" : "R2 read count", mem_req_addr, 32'd0);
        break;
      end
      @(negedge clk); n++;
    end
    chk(rsp_valid, "R10 response", {31'd0, rsp_valid}, 32'd1);
    chk(rsp_pa == e_pa, e_pg ? "R4 pa" : "R2 pa", rsp_pa, e_pa);
    chk({rsp_c_b(), rsp_ap} == {e_c, e_b, e_ap}, e_pg ? "R5 attrs" : "R2 attrs",
        {28'd0, rsp_c_b(), rsp_ap}, {28'd0, e_c, e_b, e_ap});
    chk(rsp_domain == e_dom, e_pg ? "R4 domain" : "R2 domain", {28'd0, rsp_domain}, {28'd0, e_dom});
    chk({rsp_page, rsp_fault, rsp_status} == {e_pg, e_f, e_st}, e_pg ? "R7 kind" : "R6 kind",
        {26'd0, rsp_page, rsp_fault, rsp_status}, {26'd0, e_pg, e_f, e_st});
    for (int i = 0; i < rstall; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_pa == e_pa && !req_ready, "R10 held response", rsp_pa, e_pa);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0; req_valid = 0;
    chk(req_ready && !rsp_valid, "R10 ready after handshake", {31'd0, req_ready}, 32'd1);
  endtask

  function automatic logic [1:0] rsp_c_b();
    return {rsp_cache, rsp_buffer};
  endfunction

  initial begin
    #(4ns * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req_valid && !rsp_valid, "R11 reset state",
        {29'd0, req_ready, mem_req_valid, rsp_valid}, 32'h4);
    rst_n = 1;
    // R1 R2: section example, plus base with low bits set
    walk(32'h0000_4000, 32'h1234_5678, 32'hABC0_0002, 0, 0);
    walk(32'h0000_7FFF, 32'h1234_5678, 32'hABC0_0DEE, 0, 2);
    // R3 R4 R5: coarse example, each subpage
    for (int k = 0; k < 4; k++)
      walk(32'h0000_4000, {20'h12345, k[1:0], 10'h278}, 32'hABCD_E1E1, 32'h5555_5E1E | (k << 12), 1);
    walk(32'h0001_C000, 32'h0000_0C00, 32'h0010_0041, 32'hFFFF_F1BE, 0);
    // R6: both invalid first-level codes
    walk(32'h0000_4000, 32'hFFF0_0000, 32'h1234_51E0, 0, 0);
    walk(32'h0000_4000, 32'h0000_0000, 32'h1234_51A3, 0, 1);
    // R7: invalid second-level codes
    walk(32'h0000_4000, 32'h8765_4321, 32'h0000_8021, 32'hFFFF_FFF0, 0);
    walk(32'h0000_4000, 32'h8765_4321, 32'h0000_8121, 32'hFFFF_FFF1, 0);
    walk(32'h0000_4000, 32'h8765_4321, 32'h0000_81E1, 32'hFFFF_FFF3, 2);
    for (int i = 0; i < 80; i++)
      walk($urandom, $urandom, $urandom, $urandom, $urandom_range(0, 2));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule